// File: doc/BRIEF.md
# First-Level Compressed Prefix Lookup

This unit resolves the first stage of a longest-prefix-match search over a compressed trie. A conceptual 64K-bit vector marks which 16-bit prefixes start a new route. The vector is stored as groups of sixteen bits. Each group is described by a code word that names its bit pattern and gives a small offset. A running count of set bits is kept once per four groups. From the upper sixteen bits of a 32-bit destination address the unit builds a pointer index by summation, with no population count over the vector. It then reads a 16-bit pointer that tells the next stage where to continue.

The unit takes one address per cycle and returns results in the order they arrived, after a fixed four-cycle delay. Four internal tables are filled through a single write port before lookups begin. Code words whose identifier lies above the range of real patterns mark groups with a trivial mask. For these groups the per-position offset is skipped, so the pointer sits at the base plus the code-word offset.

Top module: `lpm_l1_lookup`

## Requirements
- R1: While reset is held, and in the first cycle after, `out_valid` is low.
- R2: An address accepted with `in_valid` high in cycle N produces `out_valid` high in cycle N+4. Addresses may arrive every cycle, and results leave in arrival order.
- R3: The code word is selected by address bits 31:20. The base count is selected by address bits 31:22, so one base entry serves four neighbouring code words.
- R4: For a code word whose identifier (bits 15:6) is below 677, the pointer slot is base + code-word offset (bits 5:0) + map[identifier*16 + address bits 19:16].
- R5: For a code word whose identifier is 677 or higher, the map table is not consulted, and the pointer slot is base + code-word offset.
- R6: `out_type` carries pointer bits 15:14 (0 = next-hop index, 1 = chunk index, 2 and 3 reserved). `out_index` carries pointer bits 13:0.
- R7: A write with `wr_en` high goes to the table chosen by `wr_sel` (0 code word, 1 base count, 2 map offset in data bits 3:0, 3 pointer). The entry is `wr_addr`, and it affects lookups issued after the write.
- R8: Address bits 15:0 have no effect on the result.
- R9: In a cycle four after one with `in_valid` low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address present this cycle |
| in_addr | input | 32 | Destination address |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Target table of the write |
| wr_addr | input | 16 | Entry number within the target table |
| wr_data | input | 16 | Value written |
| out_valid | output | 1 | Result present this cycle |
| out_type | output | 2 | Pointer kind |
| out_index | output | 14 | Pointer index |

## Verification
The cycle-by-cycle properties follow the valid token across its four-cycle path, in both directions. They also confine each computed slot to the pointer array, keep identifiers that need the map table inside its stored rows, and keep load-port entry numbers within the chosen table. The bench alone can show that the sums are correct. To do so it sweeps every 16-bit prefix over tables filled by formula, so that groups sharing a base entry, trivial-mask groups and every bit position are all exercised. Independence from the low address bits, and the effect of rewriting a table during traffic, are also shown only by bench scenarios.

// File: rtl/lpm_l1_pkg.sv
package lpm_l1_pkg;
   localparam int ID_W   = 10;
   localparam int OFF_W  = 6;
   localparam int PTR_W  = 16;
   localparam int TYPE_W = 2;
   localparam int POS_W  = 4;

   typedef struct packed {
      logic [ID_W-1:0]  id;
      logic [OFF_W-1:0] off;
   } cw_t;

   typedef enum logic [1:0] {
      TBL_CW   = 2'd0,
      TBL_BASE = 2'd1,
      TBL_MAP  = 2'd2,
      TBL_PTR  = 2'd3
   } tbl_sel_e;

   typedef enum logic [TYPE_W-1:0] {
      PT_HOP   = 2'd0,
      PT_CHUNK = 2'd1,
      PT_RSV2  = 2'd2,
      PT_RSV3  = 2'd3
   } ptr_kind_e;
endpackage

// File: rtl/lpm_sram.sv
module lpm_sram #(
   parameter int W     = 16,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("lpm_sram: DEPTH must be at least 2");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/lpm_l1_index.sv
module lpm_l1_index
   import lpm_l1_pkg::*;
#(
   parameter int BASE_W     = 16,
   parameter int MAP_IDS    = 64,
   parameter int PTR_AW     = 10,
   parameter int DIRECT_MIN = 677,
   localparam int IDB       = $clog2(MAP_IDS),
   localparam int MAP_AW    = IDB + POS_W,
   localparam int SUM_W     = BASE_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              v1_i,
   input  cw_t               cw_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic [POS_W-1:0]  pos_i,
   output logic [MAP_AW-1:0] map_raddr_o,
   input  logic [POS_W-1:0]  map_off_i,
   output logic              v3_o,
   output logic [PTR_AW-1:0] idx_o
);
   if (MAP_IDS < 2 || (1 << IDB) != MAP_IDS || IDB > ID_W) begin : g_bad_map
      $error("lpm_l1_index: MAP_IDS must be a power of two within the identifier range");
   end
   if (PTR_AW >= SUM_W) begin : g_bad_ptr
      $error("lpm_l1_index: PTR_AW must be narrower than the sum");
   end

   logic direct1;
   assign direct1 = (cw_i.id >= ID_W'(DIRECT_MIN));

   // Map row: identifier picks the row, bit position picks the nibble.
   if (IDB == ID_W) begin : g_map_full
      assign map_raddr_o = {cw_i.id, pos_i};
   end else begin : g_map_fold
      assign map_raddr_o = {cw_i.id[IDB-1:0], pos_i};
   end

   // Stage 2: base plus group offset, while the map table is read.
   logic             v2, dir2;
   logic [SUM_W-1:0] part2;
   logic [ID_W-1:0]  id2;

   always_ff @(posedge clk) begin
      if (rst) v2 <= 1'b0;
      else     v2 <= v1_i;
   end

   always_ff @(posedge clk) begin
      part2 <= SUM_W'(base_i) + SUM_W'(cw_i.off);
      dir2  <= direct1;
      id2   <= cw_i.id;
   end

   // Stage 3: add the position offset unless the group is directly encoded.
   logic             v3;
   logic [SUM_W-1:0] idx_full;

   always_ff @(posedge clk) begin
      if (rst) v3 <= 1'b0;
      else     v3 <= v2;
   end

   always_ff @(posedge clk) begin
      idx_full <= part2 + (dir2 ? SUM_W'(0) : SUM_W'(map_off_i));
   end

   assign v3_o  = v3;
   assign idx_o = idx_full[PTR_AW-1:0];

   logic unused_idx_hi;
   assign unused_idx_hi = ^{idx_full[SUM_W-1:PTR_AW], id2};

   // R4: the slot sum must land inside the pointer array
   assert_idx_fits_R4: assert property (@(posedge clk) disable iff (rst)
      v3 |-> ((idx_full >> PTR_AW) == '0));

   // R5: only identifiers with a stored map row may use the map table
   assert_map_row_R5: assert property (@(posedge clk) disable iff (rst)
      (v2 && !dir2) |-> (int'(id2) < MAP_IDS));
endmodule

// File: rtl/lpm_l1_lookup.sv
module lpm_l1_lookup
   import lpm_l1_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int KEY_W      = 16,
   parameter int BASE_W     = 16,
   parameter int MAP_IDS    = 64,
   parameter int PTR_AW     = 10,
   parameter int DIRECT_MIN = 677,
   localparam int CW_W       = ID_W + OFF_W,
   localparam int CW_AW      = KEY_W - 4,
   localparam int BASE_AW    = KEY_W - 6,
   localparam int MAP_AW     = $clog2(MAP_IDS) + POS_W,
   localparam int IDX_W      = PTR_W - TYPE_W,
   localparam int CW_DEPTH   = 1 << CW_AW,
   localparam int BASE_DEPTH = 1 << BASE_AW,
   localparam int MAP_DEPTH  = 1 << MAP_AW,
   localparam int PTR_DEPTH  = 1 << PTR_AW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [31:0]       in_addr,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [15:0]       wr_addr,
   input  logic [15:0]       wr_data,
   output logic              out_valid,
   output logic [1:0]        out_type,
   output logic [13:0]       out_index
);
   if (ADDR_W != 32 || KEY_W != 16) begin : g_bad_key
      $error("lpm_l1_lookup: port widths assume a 32-bit address and 16-bit key");
   end
   if (CW_W != PTR_W || BASE_W > PTR_W) begin : g_bad_width
      $error("lpm_l1_lookup: table widths must fit the write data");
   end
   if (DIRECT_MIN >= (1 << ID_W) || MAP_IDS > DIRECT_MIN) begin : g_bad_direct
      $error("lpm_l1_lookup: direct threshold out of range");
   end
   if (PTR_AW > IDX_W) begin : g_bad_ptr
      $error("lpm_l1_lookup: pointer array deeper than the index field");
   end

   // Load port decode
   tbl_sel_e sel;
   assign sel = tbl_sel_e'(wr_sel);

   logic we_cw, we_base, we_map, we_ptr;
   assign we_cw   = wr_en && (sel == TBL_CW);
   assign we_base = wr_en && (sel == TBL_BASE);
   assign we_map  = wr_en && (sel == TBL_MAP);
   assign we_ptr  = wr_en && (sel == TBL_PTR);

   // Stage 1: code word and base count read from the key
   logic [CW_W-1:0]   cw_raw;
   logic [BASE_W-1:0] base_rd;
   logic [POS_W-1:0]  pos1;
   logic              v1;
   cw_t               cw_rd;

   lpm_sram #(.W(CW_W), .DEPTH(CW_DEPTH)) i_cw_ram (
      .clk   (clk),
      .we    (we_cw),
      .waddr (wr_addr[CW_AW-1:0]),
      .wdata (wr_data[CW_W-1:0]),
      .raddr (in_addr[ADDR_W-1 -: CW_AW]),
      .rdata (cw_raw)
   );

   lpm_sram #(.W(BASE_W), .DEPTH(BASE_DEPTH)) i_base_ram (
      .clk   (clk),
      .we    (we_base),
      .waddr (wr_addr[BASE_AW-1:0]),
      .wdata (wr_data[BASE_W-1:0]),
      .raddr (in_addr[ADDR_W-1 -: BASE_AW]),
      .rdata (base_rd)
   );

   always_ff @(posedge clk) begin
      if (rst) v1 <= 1'b0;
      else     v1 <= in_valid;
   end

   always_ff @(posedge clk) begin
      pos1 <= in_addr[ADDR_W-KEY_W +: POS_W];
   end

   assign cw_rd = cw_t'(cw_raw);

   // Stages 2 and 3: slot arithmetic around the map table read
   logic [MAP_AW-1:0] map_raddr;
   logic [POS_W-1:0]  map_rd;
   logic              v3;
   logic [PTR_AW-1:0] slot;

   lpm_sram #(.W(POS_W), .DEPTH(MAP_DEPTH)) i_map_ram (
      .clk   (clk),
      .we    (we_map),
      .waddr (wr_addr[MAP_AW-1:0]),
      .wdata (wr_data[POS_W-1:0]),
      .raddr (map_raddr),
      .rdata (map_rd)
   );

   lpm_l1_index #(
      .BASE_W     (BASE_W),
      .MAP_IDS    (MAP_IDS),
      .PTR_AW     (PTR_AW),
      .DIRECT_MIN (DIRECT_MIN)
   ) i_index (
      .clk         (clk),
      .rst         (rst),
      .v1_i        (v1),
      .cw_i        (cw_rd),
      .base_i      (base_rd),
      .pos_i       (pos1),
      .map_raddr_o (map_raddr),
      .map_off_i   (map_rd),
      .v3_o        (v3),
      .idx_o       (slot)
   );

   // Stage 4: pointer fetch
   logic [PTR_W-1:0] ptr_rd;
   logic             v4;

   lpm_sram #(.W(PTR_W), .DEPTH(PTR_DEPTH)) i_ptr_ram (
      .clk   (clk),
      .we    (we_ptr),
      .waddr (wr_addr[PTR_AW-1:0]),
      .wdata (wr_data),
      .raddr (slot),
      .rdata (ptr_rd)
   );

   always_ff @(posedge clk) begin
      if (rst) v4 <= 1'b0;
      else     v4 <= v3;
   end

   assign out_valid = v4;
   assign out_type  = ptr_rd[PTR_W-1 -: TYPE_W];
   assign out_index = ptr_rd[IDX_W-1:0];

   logic unused_in;
   assign unused_in = ^{in_addr[ADDR_W-KEY_W-1:0], wr_addr[15:CW_AW]};

   // Depth of the table the load port targets
   int wr_lim;
   always_comb begin
      unique case (sel)
         TBL_CW:   wr_lim = CW_DEPTH;
         TBL_BASE: wr_lim = BASE_DEPTH;
         TBL_MAP:  wr_lim = MAP_DEPTH;
         default:  wr_lim = PTR_DEPTH;
      endcase
   end

   // R2: every accepted address yields a result four cycles later
   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##4 out_valid);

   // R9: no result appears without an address four cycles earlier
   assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##4 !out_valid);

   // R7: load port entry numbers stay inside the chosen table
   assert_wr_range_R7: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (int'(wr_addr) < wr_lim));
endmodule

// File: tb/test_lpm_l1_lookup.sv
`timescale 1ns/1ps
module test_lpm_l1_lookup;
   import lpm_l1_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_addr = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        out_valid;
   logic [1:0]  out_type;
   logic [13:0] out_index;

   always #2 clk = ~clk;

   lpm_l1_lookup i_lpm_l1_lookup (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_addr   (in_addr),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .out_valid (out_valid),
      .out_type  (out_type),
      .out_index (out_index)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [15:0] cw_m   [4096];
   logic [15:0] base_m [1024];
   logic [3:0]  map_m  [1024];
   logic [15:0] ptr_m  [1024];

   bit          exp_v   [8];
   logic [15:0] exp_p   [8];
   string       exp_tag [8];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   function automatic bit is_direct(input logic [15:0] key);
      return int'(cw_m[key[15:4]][15:6]) >= 677;
   endfunction

   function automatic int model_slot(input logic [15:0] key);
      logic [15:0] cw;
      int mo;
      cw = cw_m[key[15:4]];
      mo = (int'(cw[15:6]) >= 677) ? 0 : int'(map_m[{cw[11:6], key[3:0]}]);
      return int'(base_m[key[15:6]]) + int'(cw[5:0]) + mo;
   endfunction

   function automatic logic [15:0] model(input logic [31:0] a);
      return ptr_m[model_slot(a[31:16]) % 1024];
   endfunction

   // Output monitor, away from the active edge
   always @(negedge clk) begin
      int s;
      if (!rst && !done) begin
         s = cyc % 8;
         if (exp_v[s]) begin
            chk(out_valid == 1'b1, "R2", "valid", 32'(out_valid), 32'd1);
            chk(out_type == exp_p[s][15:14], "R6", "type", 32'(out_type), 32'(exp_p[s][15:14]));
            chk(out_index == exp_p[s][13:0], exp_tag[s], "index", 32'(out_index), 32'(exp_p[s][13:0]));
         end else begin
            chk(out_valid == 1'b0, "R9", "idle valid", 32'(out_valid), 32'd0);
         end
         exp_v[s] = 1'b0;
      end
   end

   task automatic wr(input logic [1:0] s, input int a, input int d);
      @(negedge clk);
      in_valid = 1'b0;
      wr_en    = 1'b1;
      wr_sel   = s;
      wr_addr  = 16'(a);
      wr_data  = 16'(d);
   endtask

   task automatic look(input logic [31:0] a, input string tag);
      int s;
      @(negedge clk);
      wr_en    = 1'b0;
      in_valid = 1'b1;
      in_addr  = a;
      s = (cyc + 4) % 8;
      exp_v[s]   = 1'b1;
      exp_p[s]   = model(a);
      exp_tag[s] = tag;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         wr_en    = 1'b0;
         in_valid = 1'b0;
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) exp_v[i] = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'd0);

      // R7: fill every table through the load port
      for (int g = 0; g < 4096; g++) begin
         int id;
         id = (g % 7 == 3) ? 677 + (g % 347) : (g * 11) % 64;
         cw_m[g] = {10'(id), 6'((g * 3) % 64)};
         wr(TBL_CW, g, int'(cw_m[g]));
      end
      for (int j = 0; j < 1024; j++) begin
         base_m[j] = 16'((j * 29) % 900);
         wr(TBL_BASE, j, int'(base_m[j]));
      end
      for (int j = 0; j < 1024; j++) begin
         map_m[j] = 4'((j * 5 + 1) % 16);
         wr(TBL_MAP, j, int'(map_m[j]));
      end
      for (int k = 0; k < 1024; k++) begin
         ptr_m[k] = 16'((k * 40503) ^ 16'h3c5a);
         wr(TBL_PTR, k, int'(ptr_m[k]));
      end
      idle(2);

      // R3, R4, R5: every prefix, back to back, with gaps for R9
      for (int key = 0; key < 65536; key++) begin
         logic [15:0] low;
         low = 16'(key * 40503 + 7);
         look({16'(key), low}, is_direct(16'(key)) ? "R3 R5" : "R3 R4");
         if (key % 4096 == 4095) idle(3);
      end

      // R8: same prefix, different low bits
      for (int i = 0; i < 16; i++) look({16'hA5C3, 16'(i * 4099)}, "R8");
      idle(6);

      // R7: rewrite a pointer and a code word, then look again
      begin
         int slot;
         slot = model_slot(16'h0123);
         ptr_m[slot % 1024] = 16'h7abc;
         wr(TBL_PTR, slot % 1024, 16'h7abc);
         look({16'h0123, 16'h0000}, "R7");
         cw_m[12'h012] = {10'd700, 6'd5};
         wr(TBL_CW, 12'h012, int'(cw_m[12'h012]));
         look({16'h0127, 16'hffff}, "R7");
      end
      idle(8);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
         done = 1'b1;
         summary();
         $finish;
      end
   end
endmodule